// File: doc/BRIEF.md
# Configuration Memory Integrity Checker

This block inspects a byte-wide configuration memory every time it leaves reset, before the power controller it serves may start up. The memory holds a user section closed by a CRC byte and a manufacturing section that is kept in two copies. Each copy closes with its own CRC byte. The block reads the memory through a synchronous read port with one cycle of latency. It runs a serial CRC-8 over the user bytes and checks each manufacturing copy against its own CRC. It also compares the two manufacturing copies byte by byte.

A bad user CRC keeps the controller inactive and raises the communication/memory fault flag in the status byte and the status word. It also sets a CRC bit in a vendor status byte and pulls the open-drain style alert low. If the two manufacturing copies differ or either copy fails its CRC, the block sets a mirror-fault bit. When at least one copy passes its CRC, the block then rewrites the other copy from it through a write port. Clearing a fault through the clear-all strobe or a write-one-to-clear starts a fresh check. If a cleared mirror fault comes back on that fresh check, the block declares the memory unrecoverable.

Top module: `cfgmem_guard`

## Requirements
- R1: After every reset the check runs on its own. `check_done` is high for exactly one cycle when the check ends. `check_pass` is low from reset or from the start of a check until that end, and then holds the result.
- R2: The user CRC is CRC-8 with polynomial 0x07, initial value 0x00 and MSB first. It covers the `USER_LEN` bytes at `USER_BASE` and must equal the byte at `USER_BASE+USER_LEN`.
- R3: A user CRC mismatch sets the fault flag at bit 1 of `status_byte` and of `status_word`, sets bit 0 of `mfr_status` and drives `alert_n` low. It also leaves `check_pass` low, which keeps the controller inactive. Bit 6 of `status_byte` is always the inverse of `check_pass`.
- R4: The manufacturing copies start at `MFG_A_BASE` and `MFG_B_BASE`. Each holds `MFG_LEN` data bytes followed by one CRC byte. Any byte difference between the copies, or a CRC failure of either copy, sets bit 1 of `mfr_status` and drives `alert_n` low. With a good user section, `check_pass` is then high if at least one copy passes its CRC.
- R5: On a mirror fault with at least one passing copy, the block writes every byte of the other copy, CRC included, with the passing copy's value. Copy A is the source if it passes. When the copies agree and both pass, the block issues no write.
- R6: When neither copy passes its CRC, the block issues no write and `check_pass` stays low.
- R7: A one-cycle `clear_faults` pulse while idle clears the fault flag and `mfr_status` bits 0 and 1 and starts a new check. A repaired user section therefore brings `check_pass` high again.
- R8: A `mfr_wr` cycle while idle clears `mfr_status` bit 0 together with the fault flag when `mfr_wdata[0]` is 1. It clears `mfr_status` bit 1 when `mfr_wdata[1]` is 1. Either clear starts a new check, and all other data bits are ignored.
- R9: A mirror fault found by a check that was started by clearing bit 1 sets `mfr_status` bit 2 and drives `alert_n` low. This bit forces `check_pass` low and holds until reset.
- R10: The low byte of `status_word` equals `status_byte`. Bit 12 of `status_word` is the OR of all `mfr_status` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; each release starts a check |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the request |
| mem_wr_en | output | 1 | Repair write strobe |
| mem_wr_addr | output | AW | Repair write address |
| mem_wr_data | output | 8 | Repair write data |
| clear_faults | input | 1 | Clear-all strobe; starts a re-check |
| mfr_wr | input | 1 | Write-one-to-clear strobe for `mfr_status` |
| mfr_wdata | input | 8 | Write-one-to-clear data (bits 1:0 used) |
| status_byte | output | 8 | Bit 1 fault flag, bit 6 controller off |
| status_word | output | 16 | Low byte = status byte, bit 12 vendor summary |
| mfr_status | output | 8 | Bit 0 user CRC, bit 1 mirror fault, bit 2 unrecoverable |
| alert_n | output | 1 | Active-low alert |
| check_done | output | 1 | One-cycle pulse at the end of a check |
| check_pass | output | 1 | Check result; high permits controller start |

## Verification
A wrong internal state shows up at the ports within one check run, which takes a few dozen cycles. A miscounted index or a misaligned read tag corrupts a CRC, so `check_pass` falls and the fault bits rise on a clean image. A wrong repair source or destination becomes visible in the written memory image when `check_done` fires. A lost record of which bit was cleared shows up on the next re-check as a missing or spurious bit 2. The bench corrupts single user, data and CRC bytes in each section and then reads back both the status ports and the memory image.

// File: rtl/cfgchk_pkg.sv
package cfgchk_pkg;

    localparam logic [7:0] CRC_POLY = 8'h07;

    typedef enum logic [2:0] {
        PH_USER, PH_MIRROR, PH_DRAIN, PH_DECIDE,
        PH_REPAIR, PH_RDRAIN, PH_FINISH, PH_IDLE
    } phase_t;

    typedef enum logic [1:0] {
        RK_USER   = 2'd0,
        RK_COPY_A = 2'd1,
        RK_COPY_B = 2'd2,
        RK_REPAIR = 2'd3
    } rd_kind_t;

    typedef struct packed {
        logic     vld;
        rd_kind_t kind;
        logic     last;
    } rd_tag_t;

    typedef struct packed {
        logic user_ok;
        logic a_ok;
        logic b_ok;
        logic differ;
    } chk_result_t;

    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] x;
        x = c ^ d;
        for (int b = 0; b < 8; b++) begin
            x = x[7] ? ((x << 1) ^ CRC_POLY) : (x << 1);
        end
        return x;
    endfunction

endpackage

// File: rtl/cfgchk_crc8_acc.sv
module cfgchk_crc8_acc
    import cfgchk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= 8'h00;
        end else if (en) begin
            crc <= crc8_step(crc, din);
        end
    end
endmodule

// File: rtl/cfgchk_eval.sv
module cfgchk_eval
    import cfgchk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  rd_tag_t     tag,
    input  logic [7:0]  rdata,
    output chk_result_t res
);
    logic [2:0] ok_q;
    logic [7:0] a_hold;
    logic       differ_q;

    // one accumulator per checked section: user, copy A, copy B
    for (genvar g = 0; g < 3; g++) begin : g_sec
        localparam rd_kind_t KIND = rd_kind_t'(g);
        logic       hit;
        logic [7:0] crc_q;

        assign hit = tag.vld && (tag.kind == KIND);

        cfgchk_crc8_acc u_acc (
            .clk (clk),
            .rst (rst),
            .clr (clr),
            .en  (hit && !tag.last),
            .din (rdata),
            .crc (crc_q)
        );

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                ok_q[g] <= 1'b0;
            end else if (hit && tag.last) begin
                ok_q[g] <= (crc_q == rdata);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            a_hold   <= 8'h00;
            differ_q <= 1'b0;
        end else if (tag.vld) begin
            if (tag.kind == RK_COPY_A) begin
                a_hold <= rdata;
            end else if (tag.kind == RK_COPY_B && rdata != a_hold) begin
                differ_q <= 1'b1;
            end
        end
    end

    assign res.user_ok = ok_q[0];
    assign res.a_ok    = ok_q[1];
    assign res.b_ok    = ok_q[2];
    assign res.differ  = differ_q;
endmodule

// File: rtl/cfgchk_seq.sv
module cfgchk_seq
    import cfgchk_pkg::*;
#(
    parameter int AW         = 6,
    parameter int USER_BASE  = 0,
    parameter int USER_LEN   = 8,
    parameter int MFG_A_BASE = 16,
    parameter int MFG_B_BASE = 24,
    parameter int MFG_LEN    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  chk_result_t   res,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output rd_tag_t       tag,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          idle,
    output logic          finish
);
    localparam int LMAX = (USER_LEN > MFG_LEN) ? USER_LEN : MFG_LEN;
    localparam int IW   = $clog2(LMAX + 1);

    phase_t        phase;
    logic [IW-1:0] idx, tag_idx;
    logic          side, src_b;
    rd_tag_t       tag_n;
    logic          repair_need;
    logic          last_user, last_mfg;

    assign last_user = (idx == IW'(USER_LEN));
    assign last_mfg  = (idx == IW'(MFG_LEN));

    always_comb begin
        rd_en   = 1'b0;
        rd_addr = '0;
        tag_n   = '0;
        case (phase)
            PH_USER: begin
                rd_en      = 1'b1;
                rd_addr    = AW'(USER_BASE) + AW'(idx);
                tag_n.kind = RK_USER;
                tag_n.last = last_user;
            end
            PH_MIRROR: begin
                rd_en      = 1'b1;
                rd_addr    = (side ? AW'(MFG_B_BASE) : AW'(MFG_A_BASE)) + AW'(idx);
                tag_n.kind = side ? RK_COPY_B : RK_COPY_A;
                tag_n.last = last_mfg;
            end
            PH_REPAIR: begin
                rd_en      = 1'b1;
                rd_addr    = (src_b ? AW'(MFG_B_BASE) : AW'(MFG_A_BASE)) + AW'(idx);
                tag_n.kind = RK_REPAIR;
                tag_n.last = last_mfg;
            end
            default: ;
        endcase
        tag_n.vld = rd_en;
    end

    assign repair_need = (res.a_ok || res.b_ok) &&
                         (res.differ || !res.a_ok || !res.b_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_USER;
            idx     <= '0;
            side    <= 1'b0;
            src_b   <= 1'b0;
            tag     <= '0;
            tag_idx <= '0;
        end else begin
            tag     <= tag_n;
            tag_idx <= idx;
            case (phase)
                PH_USER: begin
                    if (last_user) begin
                        idx   <= '0;
                        phase <= PH_MIRROR;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_MIRROR: begin
                    side <= ~side;
                    if (side) begin
                        if (last_mfg) begin
                            idx   <= '0;
                            phase <= PH_DRAIN;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                PH_DRAIN:  phase <= PH_DECIDE;
                PH_DECIDE: begin
                    src_b <= !res.a_ok;
                    phase <= repair_need ? PH_REPAIR : PH_FINISH;
                end
                PH_REPAIR: begin
                    if (last_mfg) begin
                        idx   <= '0;
                        phase <= PH_RDRAIN;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_RDRAIN: phase <= PH_FINISH;
                PH_FINISH: phase <= PH_IDLE;
                default: begin
                    if (start) begin
                        idx   <= '0;
                        side  <= 1'b0;
                        phase <= PH_USER;
                    end
                end
            endcase
        end
    end

    assign wr_en   = tag.vld && (tag.kind == RK_REPAIR);
    assign wr_addr = (src_b ? AW'(MFG_A_BASE) : AW'(MFG_B_BASE)) + AW'(tag_idx);
    assign idle    = (phase == PH_IDLE);
    assign finish  = (phase == PH_FINISH);
endmodule

// File: rtl/cfgchk_status.sv
module cfgchk_status
    import cfgchk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        idle,
    input  logic        finish,
    input  chk_result_t res,
    input  logic        clear_faults,
    input  logic        mfr_wr,
    input  logic [7:0]  mfr_wdata,
    output logic        start,
    output logic        cml_q,
    output logic        crc_q,
    output logic        nvm_q,
    output logic        irrec_q,
    output logic        pass_q,
    output logic        done_q
);
    logic clr_user, clr_nvm, recheck_nvm;
    logic user_bad, nvm_fault, irrec_new;

    assign clr_user = clear_faults || (mfr_wr && mfr_wdata[0]);
    assign clr_nvm  = clear_faults || (mfr_wr && mfr_wdata[1]);
    assign start    = idle && (clr_user || clr_nvm);

    assign user_bad  = !res.user_ok;
    assign nvm_fault = res.differ || !res.a_ok || !res.b_ok;
    assign irrec_new = irrec_q || (nvm_fault && recheck_nvm);

    always_ff @(posedge clk) begin
        if (rst) begin
            cml_q       <= 1'b0;
            crc_q       <= 1'b0;
            nvm_q       <= 1'b0;
            irrec_q     <= 1'b0;
            pass_q      <= 1'b0;
            done_q      <= 1'b0;
            recheck_nvm <= 1'b0;
        end else begin
            done_q <= finish;
            if (start) begin
                pass_q      <= 1'b0;
                recheck_nvm <= clr_nvm && nvm_q;
                if (clr_user) begin
                    cml_q <= 1'b0;
                    crc_q <= 1'b0;
                end
                if (clr_nvm) begin
                    nvm_q <= 1'b0;
                end
            end else if (finish) begin
                cml_q       <= cml_q | user_bad;
                crc_q       <= crc_q | user_bad;
                nvm_q       <= nvm_q | nvm_fault;
                irrec_q     <= irrec_new;
                recheck_nvm <= 1'b0;
                pass_q      <= !user_bad && (res.a_ok || res.b_ok) && !irrec_new;
            end
        end
    end
endmodule

// File: rtl/cfgmem_guard.sv
module cfgmem_guard
    import cfgchk_pkg::*;
#(
    parameter int AW         = 6,
    parameter int USER_BASE  = 0,
    parameter int USER_LEN   = 8,
    parameter int MFG_A_BASE = 16,
    parameter int MFG_B_BASE = 24,
    parameter int MFG_LEN    = 4
) (
    input  logic          clk,
    input  logic          rst,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [7:0]    mem_rd_data,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [7:0]    mem_wr_data,
    input  logic          clear_faults,
    input  logic          mfr_wr,
    input  logic [7:0]    mfr_wdata,
    output logic [7:0]    status_byte,
    output logic [15:0]   status_word,
    output logic [7:0]    mfr_status,
    output logic          alert_n,
    output logic          check_done,
    output logic          check_pass
);
    rd_tag_t     tag;
    chk_result_t res;
    logic        idle, finish, start;
    logic        cml_q, crc_q, nvm_q, irrec_q;

    cfgchk_seq #(
        .AW(AW), .USER_BASE(USER_BASE), .USER_LEN(USER_LEN),
        .MFG_A_BASE(MFG_A_BASE), .MFG_B_BASE(MFG_B_BASE), .MFG_LEN(MFG_LEN)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .res     (res),
        .rd_en   (mem_rd_en),
        .rd_addr (mem_rd_addr),
        .tag     (tag),
        .wr_en   (mem_wr_en),
        .wr_addr (mem_wr_addr),
        .idle    (idle),
        .finish  (finish)
    );

    cfgchk_eval u_eval (
        .clk   (clk),
        .rst   (rst),
        .clr   (start),
        .tag   (tag),
        .rdata (mem_rd_data),
        .res   (res)
    );

    cfgchk_status u_stat (
        .clk          (clk),
        .rst          (rst),
        .idle         (idle),
        .finish       (finish),
        .res          (res),
        .clear_faults (clear_faults),
        .mfr_wr       (mfr_wr),
        .mfr_wdata    (mfr_wdata),
        .start        (start),
        .cml_q        (cml_q),
        .crc_q        (crc_q),
        .nvm_q        (nvm_q),
        .irrec_q      (irrec_q),
        .pass_q       (check_pass),
        .done_q       (check_done)
    );

    assign mem_wr_data = mem_rd_data;
    assign mfr_status  = {5'b0, irrec_q, nvm_q, crc_q};
    assign status_byte = {1'b0, ~check_pass, 4'b0, cml_q, 1'b0};
    assign status_word = {3'b0, |mfr_status, 4'b0, status_byte};
    assign alert_n     = ~(cml_q | nvm_q | irrec_q);
endmodule

// File: rtl/cfgmem_guard_chk.sv
module cfgmem_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       check_done,
    input logic       check_pass,
    input logic [7:0] status_byte,
    input logic [7:0] mfr_status,
    input logic       mem_wr_en
);
    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        check_done |=> !check_done);

    // R1
    pass_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(check_pass) |-> check_done);

    // R3
    pass_gate_chk: assert property (@(posedge clk) disable iff (rst)
        check_pass |-> !status_byte[1]);

    // R5
    write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> !check_pass && !check_done);

    // R9
    irrec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mfr_status[2] |=> mfr_status[2]);

    // R9
    irrec_pass_chk: assert property (@(posedge clk) disable iff (rst)
        mfr_status[2] |-> !check_pass);
endmodule

bind cfgmem_guard cfgmem_guard_chk u_guard_chk (
    .clk         (clk),
    .rst         (rst),
    .check_done  (check_done),
    .check_pass  (check_pass),
    .status_byte (status_byte),
    .mfr_status  (mfr_status),
    .mem_wr_en   (mem_wr_en)
);

// File: tb/test_cfgmem_guard.sv
module test_cfgmem_guard;
    localparam int AW = 6;
    localparam int UB = 0, UL = 8, AB = 16, BB = 24, ML = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]    mem_rd_data = 8'h00;
    logic [7:0]    mem_wr_data;
    logic          clear_faults = 1'b0;
    logic          mfr_wr = 1'b0;
    logic [7:0]    mfr_wdata = 8'h00;
    logic [7:0]    status_byte, mfr_status;
    logic [15:0]   status_word;
    logic          alert_n, check_done, check_pass;

    logic [7:0] mem  [64];
    logic [7:0] gold [64];
    int n_checks = 0;
    int n_err    = 0;
    int wr_count = 0;

    always #10 clk = ~clk;

    cfgmem_guard i_cfgmem_guard (
        .clk(clk), .rst(rst),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .clear_faults(clear_faults), .mfr_wr(mfr_wr), .mfr_wdata(mfr_wdata),
        .status_byte(status_byte), .status_word(status_word), .mfr_status(mfr_status),
        .alert_n(alert_n), .check_done(check_done), .check_pass(check_pass)
    );

    always @(posedge clk) begin
        if (mem_wr_en) begin
            mem[mem_wr_addr] <= mem_wr_data;
            wr_count <= wr_count + 1;
        end
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    end

    function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] x = c ^ d;
        for (int b = 0; b < 8; b++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        return x;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load_good();
        logic [7:0] c;
        for (int i = 0; i < 64; i++) gold[i] = 8'h00;
        c = 8'h00;
        for (int i = 0; i < UL; i++) begin
            gold[UB+i] = 8'(8'h31 + i * 8'h17);
            c = crc8(c, gold[UB+i]);
        end
        gold[UB+UL] = c;
        c = 8'h00;
        for (int i = 0; i < ML; i++) begin
            gold[AB+i] = 8'(8'h5A ^ (i * 8'h1D));
            gold[BB+i] = gold[AB+i];
            c = crc8(c, gold[AB+i]);
        end
        gold[AB+ML] = c;
        gold[BB+ML] = c;
        for (int i = 0; i < 64; i++) mem[i] = gold[i];
    endtask

    task automatic wait_done(input string req);
        bit seen = 0;
        for (int k = 0; k < 500 && !seen; k++) begin
            @(negedge clk);
            if (check_done) seen = 1;
        end
        check({req, " done seen"}, 32'(seen), 32'd1);
    endtask

    task automatic por();
        wr_count = 0;
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        wait_done("R1");
    endtask

    task automatic pulse_clear();
        wr_count = 0;
        clear_faults = 1'b1;
        @(negedge clk); clear_faults = 1'b0;
    endtask

    task automatic pulse_w1c(input logic [7:0] d);
        wr_count = 0;
        mfr_wr = 1'b1; mfr_wdata = d;
        @(negedge clk); mfr_wr = 1'b0; mfr_wdata = 8'h00;
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset done",   32'(check_done), 32'd0);
        check("R1 reset pass",   32'(check_pass), 32'd0);
        check("R3 reset status", 32'(status_byte), 32'h40);
        check("R3 reset alert",  32'(alert_n), 32'd1);
        rst = 1'b0;
        wait_done("R1");
    endtask

    task automatic t_clean();
        por();
        check("R2 clean pass",   32'(check_pass), 32'd1);
        check("R2 clean status", 32'(status_byte), 32'h00);
        check("R10 clean word",  32'(status_word), 32'h0000);
        check("R4 clean mfr",    32'(mfr_status), 32'h00);
        check("R4 clean alert",  32'(alert_n), 32'd1);
        check("R5 no writes",    32'(wr_count), 32'd0);
        @(negedge clk);
        check("R1 done one cycle", 32'(check_done), 32'd0);
        check("R1 pass held",      32'(check_pass), 32'd1);
    endtask

    task automatic t_user_bad();
        mem[UB+3] = mem[UB+3] ^ 8'h10;
        por();
        check("R3 user pass",   32'(check_pass), 32'd0);
        check("R3 user status", 32'(status_byte), 32'h42);
        check("R10 user word",  32'(status_word), 32'h1042);
        check("R3 user mfr",    32'(mfr_status), 32'h01);
        check("R3 user alert",  32'(alert_n), 32'd0);
        mem[UB+3] = gold[UB+3];
        pulse_clear();
        wait_done("R7");
        check("R7 fixed pass",   32'(check_pass), 32'd1);
        check("R7 fixed status", 32'(status_byte), 32'h00);
        check("R7 fixed mfr",    32'(mfr_status), 32'h00);
        check("R7 fixed alert",  32'(alert_n), 32'd1);
    endtask

    task automatic t_user_crc_byte_w1c();
        mem[UB+UL] = mem[UB+UL] ^ 8'h01;
        por();
        check("R2 crc byte fault", 32'(mfr_status), 32'h01);
        mem[UB+UL] = gold[UB+UL];
        pulse_w1c(8'hFC);
        repeat (40) @(negedge clk);
        check("R8 ignored bits",   32'(mfr_status), 32'h01);
        pulse_w1c(8'h01);
        wait_done("R8");
        check("R8 w1c mfr",    32'(mfr_status), 32'h00);
        check("R8 w1c status", 32'(status_byte), 32'h00);
        check("R8 w1c pass",   32'(check_pass), 32'd1);
    endtask

    task automatic t_mirror_b_bad();
        mem[BB+2] = mem[BB+2] ^ 8'h04;
        por();
        check("R4 b mfr",   32'(mfr_status), 32'h02);
        check("R4 b alert", 32'(alert_n), 32'd0);
        check("R4 b pass",  32'(check_pass), 32'd1);
        check("R5 b writes", 32'(wr_count), 32'(ML + 1));
        check("R5 b repaired", 32'(mem[BB+2]), 32'(gold[BB+2]));
        pulse_w1c(8'h02);
        wait_done("R8");
        check("R8 b cleared", 32'(mfr_status), 32'h00);
        check("R9 b no irrec alert", 32'(alert_n), 32'd1);
    endtask

    task automatic t_mirror_a_bad();
        mem[AB+ML] = mem[AB+ML] ^ 8'h01;
        por();
        check("R4 a mfr", 32'(mfr_status), 32'h02);
        check("R5 a repaired crc", 32'(mem[AB+ML]), 32'(gold[AB+ML]));
        check("R5 a b untouched",  32'(mem[BB+ML]), 32'(gold[BB+ML]));
        check("R4 a pass", 32'(check_pass), 32'd1);
    endtask

    task automatic t_both_bad();
        mem[AB+1] = mem[AB+1] ^ 8'h01;
        mem[BB+1] = mem[BB+1] ^ 8'h02;
        por();
        check("R6 both mfr",   32'(mfr_status), 32'h02);
        check("R6 both pass",  32'(check_pass), 32'd0);
        check("R6 both writes", 32'(wr_count), 32'd0);
        check("R6 both b kept", 32'(mem[BB+1]), 32'(gold[BB+1] ^ 8'h02));
        pulse_clear();
        wait_done("R9");
        check("R9 irrec mfr",   32'(mfr_status), 32'h06);
        check("R9 irrec pass",  32'(check_pass), 32'd0);
        check("R9 irrec alert", 32'(alert_n), 32'd0);
        for (int i = 0; i < 64; i++) mem[i] = gold[i];
        pulse_clear();
        wait_done("R9");
        check("R9 irrec held",  32'(mfr_status), 32'h04);
        check("R9 pass forced", 32'(check_pass), 32'd0);
        por();
        check("R9 reset clears", 32'(mfr_status), 32'h00);
        check("R9 reset pass",   32'(check_pass), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
        $finish;
    end

    initial begin
        load_good();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        wait_done("R1");
        t_reset();
        t_clean();
        t_user_bad();
        t_user_crc_byte_w1c();
        t_mirror_b_bad();
        t_mirror_a_bad();
        t_both_bad();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule